// File: doc/BRIEF.md
# Memory-to-Peripheral DMA Engine

This block is a single-channel copy engine. Software programs a source address, a destination address, a byte count and a control word through a small register port. It then sets a start bit. A read master fetches one beat at a time and pushes each beat into a shallow FIFO. A write master drains that FIFO to the destination. Both masters use a simple request/wait-request bus. A beat is accepted in any cycle where the request is high and wait-request is low. Read data is returned in the same cycle that the read is accepted.

The control word selects the beat width: 1, 2, 4, 8 or 16 bytes. It also selects, for each side on its own, whether the address steps by that width or stays fixed. A fixed address lets the engine stream into or out of a peripheral data register. The remaining byte count falls by one beat width on each accepted write. When the count reaches zero, the engine goes idle, flags completion and can raise an interrupt.

Register map (index on `csr_addr`):

- 0: status. Read gives bit0 = done and bit1 = busy. Any write clears done.
- 1: source address.
- 2: destination address.
- 3: remaining byte count.
- 4: control. Bits [2:0] hold the width code, bit3 holds the source fixed-address flag, bit4 holds the destination fixed-address flag and bit5 holds the interrupt enable. Bit6 is the start bit; it is not stored.

Top module: `mdma_core`

## Requirements
- R1: After reset, every register reads 0, the done and busy bits are 0, and `irq`, `rd_req` and `wr_req` are low.
- R2: Width codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bytes per beat. Each accepted access on a side moves that side's address up by the beat size. Codes 5 to 7 act as the widest width the data path carries, which is 16 bytes at the default width.
- R3: When a side's fixed-address flag is set, that side's address does not change during the transfer. The flag takes priority over the width-based step.
- R4: The read master issues a read only while the FIFO has a free slot. With the write side stalled, exactly 2 reads are accepted at the default depth.
- R5: The write master requests only while the FIFO holds data. The beats it writes carry the read data in read order.
- R6: A request held off by wait-request stays asserted with an unchanged address until it is accepted.
- R7: The byte count falls by the beat size on each accepted write. At zero, done reads 1 and busy reads 0.
- R8: `irq` is high exactly when done is set and the interrupt enable (control bit5) is set.
- R9: Any write to the status register clears done and drops `irq`.
- R10: While busy is set, writes to the address, count and control registers are ignored. A second start is also ignored.
- R11: A start with a byte count of 0 sets done on the next cycle. Busy stays 0 and no read or write is issued.
- R12: A transfer issues exactly count/beat-size reads and the same number of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register index for both reads and writes |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Combinational read-back of the register at `csr_addr` |
| irq | output | 1 | Completion interrupt |
| rd_req | output | 1 | Read request |
| rd_address | output | ADDR_W | Read byte address |
| rd_wait | input | 1 | Read wait-request from the slave |
| rd_rdata | input | DATA_W | Read data, valid in the accept cycle |
| wr_req | output | 1 | Write request |
| wr_address | output | ADDR_W | Write byte address |
| wr_wdata | output | DATA_W | Write data |
| wr_wait | input | 1 | Write wait-request from the slave |

## Verification
The hardest state to reach from the ports is a full FIFO while a transfer is still in flight. This state is needed to show both the two-entry limit on outstanding reads and that register writes are locked during busy. The bench holds the destination wait-request high from the start of a transfer, so the FIFO fills. It then counts accepted reads and rewrites the count, address and control registers while the FIFO is full. Finally it releases the stall and lets the scoreboard confirm that the transfer finished with its original settings. Other transfers run with pseudo-random wait-request on both sides, across every width code and both fixed-address flags.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_RADDR = 3'd1,
    REG_WADDR = 3'd2,
    REG_LEN   = 3'd3,
    REG_CTRL  = 3'd4
  } reg_idx_e;

  localparam int unsigned GO_BIT = 6;

  typedef struct packed {
    logic       irq_en;
    logic       wr_fix;
    logic       rd_fix;
    logic [2:0] width;
  } ctrl_t;

  // bytes per beat for a width code, clamped to the data path
  function automatic logic [4:0] beat_bytes(input logic [2:0] code,
                                            input logic [2:0] max_code);
    logic [2:0] c;
    c = (code > max_code) ? max_code : code;
    return 5'd1 << c;
  endfunction

  // address step: a fixed-address flag wins over the width
  function automatic logic [4:0] addr_step(input logic [2:0] code,
                                           input logic       fix,
                                           input logic [2:0] max_code);
    return fix ? 5'd0 : beat_bytes(code, max_code);
  endfunction

endpackage

// File: rtl/mdma_regs.sv
module mdma_regs
  import mdma_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 32,
  parameter logic [2:0]  MAX_CODE = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [2:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              rd_acc,
  input  logic              wr_acc,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              start,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  len,
  output logic [4:0]        beat_b
);

  logic              busy_q, done_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [LEN_W-1:0]  len_q;
  ctrl_t             ctrl_q;
  logic              go_req, stat_wr, last_beat;
  logic [4:0]        rd_step, wr_step;

  assign go_req    = csr_wr && (csr_addr == REG_CTRL) && csr_wdata[GO_BIT] && !busy_q;
  assign start     = go_req && (len_q != '0);
  assign stat_wr   = csr_wr && (csr_addr == REG_STAT);
  assign beat_b    = beat_bytes(ctrl_q.width, MAX_CODE);
  assign rd_step   = addr_step(ctrl_q.width, ctrl_q.rd_fix, MAX_CODE);
  assign wr_step   = addr_step(ctrl_q.width, ctrl_q.wr_fix, MAX_CODE);
  assign last_beat = wr_acc && (len_q == LEN_W'(beat_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      len_q     <= '0;
      ctrl_q    <= '0;
    end else begin
      if (csr_wr && !busy_q) begin
        case (csr_addr)
          REG_RADDR: rd_addr_q <= csr_wdata[ADDR_W-1:0];
          REG_WADDR: wr_addr_q <= csr_wdata[ADDR_W-1:0];
          REG_LEN:   len_q     <= csr_wdata[LEN_W-1:0];
          REG_CTRL:  ctrl_q    <= ctrl_t'(csr_wdata[5:0]);
          default:   ;
        endcase
      end
      if (stat_wr) done_q <= 1'b0;
      if (go_req) begin
        busy_q <= (len_q != '0);
        done_q <= (len_q == '0);
      end
      if (busy_q && rd_acc) rd_addr_q <= rd_addr_q + ADDR_W'(rd_step);
      if (busy_q && wr_acc) begin
        wr_addr_q <= wr_addr_q + ADDR_W'(wr_step);
        len_q     <= len_q - LEN_W'(beat_b);
      end
      if (busy_q && last_beat) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (csr_addr)
      REG_STAT:  csr_rdata = {30'd0, busy_q, done_q};
      REG_RADDR: csr_rdata = 32'(rd_addr_q);
      REG_WADDR: csr_rdata = 32'(wr_addr_q);
      REG_LEN:   csr_rdata = 32'(len_q);
      REG_CTRL:  csr_rdata = {26'd0, ctrl_q};
      default:   csr_rdata = 32'd0;
    endcase
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign irq     = done_q && ctrl_q.irq_en;
  assign rd_addr = rd_addr_q;
  assign wr_addr = wr_addr_q;
  assign len     = len_q;

  AST_RD_FIX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ctrl_q.rd_fix && rd_acc |=> $stable(rd_addr_q)); // R3
  AST_WR_FIX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ctrl_q.wr_fix && wr_acc |=> $stable(wr_addr_q)); // R3
  AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && csr_wr && (csr_addr == REG_LEN) && !wr_acc |=> $stable(len_q)); // R10
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && (len_q == '0) |=> done_q && !busy_q); // R11

endmodule

// File: rtl/mdma_rd_master.sv
module mdma_rd_master #(
  parameter int unsigned LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_init,
  input  logic [4:0]       beat_b,
  input  logic             fifo_full,
  input  logic             rd_wait,
  output logic             rd_req,
  output logic             rd_acc
);

  logic [LEN_W-1:0] left_q;

  assign rd_req = (left_q != '0) && !fifo_full;
  assign rd_acc = rd_req && !rd_wait;

  always_ff @(posedge clk) begin
    if (!rst_n)      left_q <= '0;
    else if (start)  left_q <= len_init;
    else if (rd_acc) left_q <= left_q - LEN_W'(beat_b);
  end

  AST_RD_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> left_q >= LEN_W'(beat_b)); // R12

endmodule

// File: rtl/mdma_fifo.sv
module mdma_fifo #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5

endmodule

// File: rtl/mdma_wr_master.sv
module mdma_wr_master (
  input  logic busy,
  input  logic fifo_empty,
  input  logic wr_wait,
  output logic wr_req,
  output logic wr_acc
);

  assign wr_req = busy && !fifo_empty;
  assign wr_acc = wr_req && !wr_wait;

endmodule

// File: rtl/mdma_core.sv
module mdma_core
  import mdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 128,
  parameter int unsigned LEN_W      = 32,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [2:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_address,
  input  logic              rd_wait,
  input  logic [DATA_W-1:0] rd_rdata,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_address,
  output logic [DATA_W-1:0] wr_wdata,
  input  logic              wr_wait
);

  localparam logic [2:0]  MAX_CODE = 3'($clog2(DATA_W/8));
  localparam int unsigned CNT_W    = $clog2(FIFO_DEPTH+1);

  logic             busy, done, start, rd_acc, wr_acc;
  logic             fifo_full, fifo_empty;
  logic [CNT_W-1:0] fifo_cnt;
  logic [LEN_W-1:0] len;
  logic [4:0]       beat_b;

  mdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_CODE(MAX_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rd_acc(rd_acc),
    .wr_acc(wr_acc), .busy(busy), .done(done), .irq(irq), .start(start),
    .rd_addr(rd_address), .wr_addr(wr_address), .len(len), .beat_b(beat_b)
  );

  mdma_rd_master #(.LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(start), .len_init(len), .beat_b(beat_b),
    .fifo_full(fifo_full), .rd_wait(rd_wait), .rd_req(rd_req), .rd_acc(rd_acc)
  );

  mdma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rd_acc), .din(rd_rdata), .pop(wr_acc),
    .dout(wr_wdata), .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt)
  );

  mdma_wr_master u_wr (
    .busy(busy), .fifo_empty(fifo_empty), .wr_wait(wr_wait),
    .wr_req(wr_req), .wr_acc(wr_acc)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_req); // R11
  AST_WR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> fifo_cnt != '0); // R5
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_wait |=> rd_req && $stable(rd_address)); // R6
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_wait |=> wr_req && $stable(wr_address)); // R6
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy); // R7
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R8

endmodule

// File: tb/mdma_core_bench.sv
module mdma_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csr_wr = 1'b0;
  logic [2:0]   csr_addr = 3'd0;
  logic [31:0]  csr_wdata = 32'd0;
  logic [31:0]  csr_rdata;
  logic         irq, rd_req, wr_req;
  logic [31:0]  rd_address, wr_address;
  logic         rd_wait = 1'b0, wr_wait = 1'b0;
  logic [127:0] rd_rdata, wr_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  int stall_mode = 0;
  int cycles = 0;
  logic [15:0]  lfsr = 16'hACE1;
  logic [159:0] exp_q [$];
  logic         prev_stall = 1'b0;
  logic [31:0]  prev_raddr = '0;

  mdma_core u_mdma_core (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .rd_req(rd_req), .rd_address(rd_address), .rd_wait(rd_wait),
    .rd_rdata(rd_rdata), .wr_req(wr_req), .wr_address(wr_address),
    .wr_wdata(wr_wdata), .wr_wait(wr_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] model(input logic [31:0] a);
    return {a, ~a, a ^ 32'h5A5A_5A5A, a + 32'h0000_1234};
  endfunction

  assign rd_rdata = model(rd_address);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FIFO-less FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // wait-request generator, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_wait = (stall_mode == 1) && lfsr[0];
    wr_wait = (stall_mode == 2) || ((stall_mode == 1) && lfsr[3]);
  end

  // monitor: scoreboard pops on each accepted write
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && rd_req)
        chk(rd_address == prev_raddr, "R6", rd_address, prev_raddr);
      prev_stall = rd_req && rd_wait;
      prev_raddr = rd_address;
      if (rd_req && !rd_wait) rd_cnt++;
      if (wr_req && !wr_wait) begin
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected write", wr_address, 0);
        end else begin
          logic [159:0] e;
          e = exp_q.pop_front();
          chk({wr_address, wr_wdata} == e, "R5 write beat", wr_address, e[159:128]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  function automatic int bytes_of(input int code);
    return 1 << ((code > 4) ? 4 : code);
  endfunction

  // driver: queue expected beats, program and start
  task automatic start_xfer(input int code, input bit rfix, input bit wfix,
                            input bit ien, input logic [31:0] ra,
                            input logic [31:0] wa, input int len, input int mode);
    int wb, rs, ws;
    wb = bytes_of(code);
    rs = rfix ? 0 : wb;
    ws = wfix ? 0 : wb;
    for (int i = 0; i < len / wb; i++)
      exp_q.push_back({wa + 32'(i * ws), model(ra + 32'(i * rs))});
    stall_mode = mode;
    rd_cnt = 0;
    wr_cnt = 0;
    csr_write(3'd1, ra);
    csr_write(3'd2, wa);
    csr_write(3'd3, 32'(len));
    csr_write(3'd4, 32'(code) | (32'(rfix) << 3) | (32'(wfix) << 4) |
                    (32'(ien) << 5) | 32'h40);
  endtask

  task automatic finish_xfer(input int code, input bit rfix, input bit wfix,
                             input bit ien, input logic [31:0] ra,
                             input logic [31:0] wa, input int len);
    logic [31:0] d;
    int wb, n;
    wb = bytes_of(code);
    n  = len / wb;
    for (int k = 0; k < 5000; k++) begin
      csr_read(3'd0, d);
      if (d[0]) break;
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all beats written", exp_q.size(), 0);
    chk(rd_cnt == n, "R12 read count", rd_cnt, n);
    chk(wr_cnt == n, "R12 write count", wr_cnt, n);
    csr_read(3'd0, d);
    chk(d == 32'd1, "R7 done set busy clear", d, 1);
    chk(irq == ien, "R8 irq follows enable", irq, ien);
    csr_read(3'd3, d);
    chk(d == 0, "R7 count at zero", d, 0);
    csr_read(3'd1, d);
    chk(d == ra + 32'(rfix ? 0 : n * wb), rfix ? "R3 read addr fixed" : "R2 read addr step",
        d, ra + 32'(rfix ? 0 : n * wb));
    csr_read(3'd2, d);
    chk(d == wa + 32'(wfix ? 0 : n * wb), wfix ? "R3 write addr fixed" : "R2 write addr step",
        d, wa + 32'(wfix ? 0 : n * wb));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      csr_read(3'(r), d);
      chk(d == 0, "R1 register reset", d, 0);
    end
    chk(!rd_req && !wr_req && !irq, "R1 quiet outputs", {rd_req, wr_req, irq}, 0);

    // R2 R12 every width, no stall and random stalls
    start_xfer(2, 0, 0, 1, 32'h0000_1000, 32'h0000_8000, 64, 0);
    finish_xfer(2, 0, 0, 1, 32'h0000_1000, 32'h0000_8000, 64);
    start_xfer(0, 0, 0, 0, 32'h0000_2001, 32'h0000_9003, 7, 1);
    finish_xfer(0, 0, 0, 0, 32'h0000_2001, 32'h0000_9003, 7);
    start_xfer(3, 0, 0, 1, 32'h0000_3000, 32'h0000_A000, 8, 1);
    finish_xfer(3, 0, 0, 1, 32'h0000_3000, 32'h0000_A000, 8);
    start_xfer(4, 0, 0, 0, 32'h0000_4000, 32'h0000_B000, 96, 1);
    finish_xfer(4, 0, 0, 0, 32'h0000_4000, 32'h0000_B000, 96);
    // R2 code 7 clamps to 16 bytes
    start_xfer(7, 0, 0, 0, 32'h0000_5000, 32'h0000_C000, 48, 1);
    finish_xfer(7, 0, 0, 0, 32'h0000_5000, 32'h0000_C000, 48);

    // R3 fixed source, then fixed destination
    start_xfer(1, 1, 0, 1, 32'h0000_0F00, 32'h0000_D000, 20, 1);
    finish_xfer(1, 1, 0, 1, 32'h0000_0F00, 32'h0000_D000, 20);
    start_xfer(0, 0, 1, 0, 32'h0000_6000, 32'h0000_0E04, 13, 1);
    finish_xfer(0, 0, 1, 0, 32'h0000_6000, 32'h0000_0E04, 13);

    // R9 status write clears done and irq
    start_xfer(2, 0, 0, 1, 32'h0000_7000, 32'h0000_E000, 16, 0);
    finish_xfer(2, 0, 0, 1, 32'h0000_7000, 32'h0000_E000, 16);
    csr_write(3'd0, 32'd0);
    csr_read(3'd0, d);
    chk(d == 0, "R9 done cleared", d, 0);
    chk(irq == 1'b0, "R9 irq dropped", irq, 0);

    // R4 and R10: write side stalled, FIFO fills, registers locked
    start_xfer(2, 0, 0, 1, 32'h0001_0000, 32'h0002_0000, 32, 2);
    repeat (30) @(negedge clk);
    chk(rd_cnt == 2, "R4 reads limited by FIFO depth", rd_cnt, 2);
    chk(wr_cnt == 0, "R5 no write while stalled", wr_cnt, 0);
    csr_write(3'd1, 32'hDEAD_0000);
    csr_write(3'd3, 32'd999);
    csr_write(3'd4, 32'h0000_0058);
    csr_read(3'd3, d);
    chk(d == 32, "R10 count write ignored", d, 32);
    csr_read(3'd1, d);
    chk(d == 32'h0001_0008, "R10 address write ignored", d, 32'h0001_0008);
    csr_read(3'd4, d);
    chk(d == 32'h22, "R10 control write ignored", d, 32'h22);
    stall_mode = 0;
    finish_xfer(2, 0, 0, 1, 32'h0001_0000, 32'h0002_0000, 32);

    // R11 zero-length start
    csr_write(3'd0, 32'd0);
    rd_cnt = 0;
    wr_cnt = 0;
    csr_write(3'd3, 32'd0);
    csr_write(3'd4, 32'h0000_0062);
    csr_read(3'd0, d);
    chk(d == 32'd1, "R11 done at once, not busy", d, 1);
    repeat (5) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0, "R11 no bus activity", rd_cnt + wr_cnt, 0);
    chk(irq == 1'b1, "R8 irq on zero-length done", irq, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule